// File: doc/BRIEF.md
# Second-Level Interrupt Aggregator

This block gathers 32 interrupt sources into one request line to a parent interrupt controller. Each source has one bit in every register. A per-source mask bit decides whether that source may raise the request. The request is registered and stays high while any source is pending and unmasked. Software reaches the block through a simple 32-bit register port. A request carries a valid strobe, a write flag, a byte offset and write data. Read data comes back registered on the cycle after the read.

A build-time parameter picks one of two variants. In the latched variant, a rising edge on a source sets a sticky status bit, and software clears that bit by writing a one to the clear register. In the level variant, the status register shows the raw input levels and there is no clear register. In both variants the mask can only be changed through two registers: one that sets mask bits and one that clears them.

Top module: `l2_irq_agg`

## Requirements
- R1: After reset, all mask bits are 1 (every source masked), every latched status bit is 0, `irq_o` is 0 and `rd_data` is 0.
- R2: Latched variant: a 0-to-1 change of `src_i[i]`, sampled on a clock edge, sets status bit i on that edge. The bit stays 1 after the input returns to 0. The status register is at offset 0x00.
- R3: Latched variant: writing to offset 0x08 clears each status bit whose write-data bit is 1. Write-data bits that are 0 leave their status bits unchanged.
- R4: Latched variant: if a rising edge and a clear of the same bit arrive in the same cycle, the status bit ends up as 1.
- R5: Level variant: the status register at offset 0x00 reads the current levels of `src_i`. The variant has no clear register.
- R6: Writing to the mask-set register masks each source whose write-data bit is 1. The offset is 0x10 in the latched variant and 0x08 in the level variant. Zero bits leave the mask unchanged, so writing all ones masks every source.
- R7: Writing to the mask-clear register unmasks each source whose write-data bit is 1. The offset is 0x14 in the latched variant and 0x0C in the level variant. Zero bits leave the mask unchanged.
- R8: The mask-status register reads the current mask, with 1 meaning masked. The offset is 0x0C in the latched variant and 0x04 in the level variant.
- R9: `irq_o` is registered. On each clock edge it takes the OR, over all sources, of (status bit AND NOT mask bit). So it follows a status or mask change one cycle later.
- R10: A read returns zero on `rd_data` for an unmapped offset or a write-only register. A write to a read-only offset or an unmapped offset changes no state. Read data appears on the cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the sources are synchronous to it |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | NSRC (32) | Interrupt source inputs |
| req_valid | input | 1 | Register access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (8) | Byte offset of the register |
| req_wdata | input | NSRC (32) | Write data, one bit per source |
| rd_data | output | NSRC (32) | Registered read data |
| irq_o | output | 1 | Registered request to the parent controller |

## Verification
The assertions assume the sources change only between clock edges. They also assume at most one register access per cycle, so a mask set and a mask clear never arrive in the same cycle. The bench meets both conditions. It drives every input, sources and bus alike, on the falling clock edge, and it issues each access as a single-cycle strobe. The bench sweeps all 32 sources one at a time in each variant, and its expected status, mask and request values are computed from a mask model kept in the bench.

// File: rtl/l2_irq_pkg.sv
// Package: shared register-select type and the offset decode for both variants.
// Assumes byte offsets; an offset that matches no register decodes to SEL_NONE.
package l2_irq_pkg;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STAT,
        SEL_CLR,
        SEL_MSTAT,
        SEL_MSET,
        SEL_MCLR
    } regsel_t;

    // Latched variant offsets
    localparam logic [7:0] LAT_STAT  = 8'h00;
    localparam logic [7:0] LAT_CLR   = 8'h08;
    localparam logic [7:0] LAT_MSTAT = 8'h0C;
    localparam logic [7:0] LAT_MSET  = 8'h10;
    localparam logic [7:0] LAT_MCLR  = 8'h14;
    // Level variant offsets
    localparam logic [7:0] LVL_STAT  = 8'h00;
    localparam logic [7:0] LVL_MSTAT = 8'h04;
    localparam logic [7:0] LVL_MSET  = 8'h08;
    localparam logic [7:0] LVL_MCLR  = 8'h0C;

    // Map a byte offset to a register select for the chosen variant.
    function automatic regsel_t decode_offset(input logic [7:0] off, input bit latched);
        regsel_t s;
        s = SEL_NONE;
        if (latched) begin
            case (off)
                LAT_STAT:  s = SEL_STAT;
                LAT_CLR:   s = SEL_CLR;
                LAT_MSTAT: s = SEL_MSTAT;
                LAT_MSET:  s = SEL_MSET;
                LAT_MCLR:  s = SEL_MCLR;
                default:   s = SEL_NONE;
            endcase
        end else begin
            case (off)
                LVL_STAT:  s = SEL_STAT;
                LVL_MSTAT: s = SEL_MSTAT;
                LVL_MSET:  s = SEL_MSET;
                LVL_MCLR:  s = SEL_MCLR;
                default:   s = SEL_NONE;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/l2_reg_decode.sv
// Module: register decode. It turns one bus request into a register select and
// into write strobes for the clear, mask-set and mask-clear registers.
// Assumes ADDR_W >= 8 and at most one request per cycle; address bits above
// bit 7 must be zero for a hit.
module l2_reg_decode
    import l2_irq_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter bit LATCHED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output regsel_t           sel,
    output logic              clr_we,
    output logic              mset_we,
    output logic              mclr_we
);
    localparam int HI_W = ADDR_W - 8;

    logic hi_zero;

    // Upper address bits must be zero for any register hit.
    generate
        if (HI_W > 0) begin : g_hi
            assign hi_zero = (req_addr[ADDR_W-1:8] == '0);
        end else begin : g_nohi
            assign hi_zero = 1'b1;
        end
    endgenerate

    // Offset decode through the shared package function.
    always_comb begin
        sel = hi_zero ? decode_offset(req_addr[7:0], LATCHED) : SEL_NONE;
    end

    // Write strobes, one per writable register.
    always_comb begin
        clr_we  = req_valid && req_write && (sel == SEL_CLR);
        mset_we = req_valid && req_write && (sel == SEL_MSET);
        mclr_we = req_valid && req_write && (sel == SEL_MCLR);
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({clr_we, mset_we, mclr_we}));                          // R10
    AST_NO_WRITE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |-> !(clr_we || mset_we || mclr_we)); // R10

endmodule

// File: rtl/l2_mask_bank.sv
// Module: per-source mask register. It is changed only through the set and the
// clear strobes, and each one-bit in the write data acts on its own source.
// Assumes the set and clear strobes are never active in the same cycle.
module l2_mask_bank #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mset_we,
    input  logic            mclr_we,
    input  logic [NSRC-1:0] wdata,
    output logic [NSRC-1:0] mask
);
    // Mask update: reset masks every source; set ORs bits in, clear ANDs them out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '1;
        end else if (mset_we) begin
            mask <= mask | wdata;
        end else if (mclr_we) begin
            mask <= mask & ~wdata;
        end
    end

    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        mset_we |=> ((mask & $past(wdata)) == $past(wdata)));            // R6
    AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        mclr_we |=> ((mask & $past(wdata)) == '0));                     // R7
    AST_MASK_SET_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        mset_we |=> ((mask & ~$past(wdata)) == ($past(mask) & ~$past(wdata)))); // R6
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mset_we && !mclr_we) |=> $stable(mask));                      // R6

endmodule

// File: rtl/l2_src_capture.sv
// Module: source status. In the latched variant it registers the previous input
// value, sets sticky bits on rising edges and clears them on write-one-to-clear.
// If an edge and a clear hit the same bit in the same cycle, the edge wins.
// In the level variant the status is the raw input. Inputs are synchronous to clk.
module l2_src_capture #(
    parameter int NSRC    = 32,
    parameter bit LATCHED = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic            clr_we,
    input  logic [NSRC-1:0] wdata,
    output logic [NSRC-1:0] status
);
    generate
        if (LATCHED) begin : g_latch
            logic [NSRC-1:0] prev_q;
            logic [NSRC-1:0] stat_q;
            logic [NSRC-1:0] rise;
            logic [NSRC-1:0] clr_bits;

            // Edge detect and clear-bit gating.
            always_comb begin
                rise     = src_i & ~prev_q;
                clr_bits = clr_we ? wdata : '0;
            end

            // Sticky status update: a new edge is ORed in after the clear, so the edge wins.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    prev_q <= '0;
                    stat_q <= '0;
                end else begin
                    prev_q <= src_i;
                    stat_q <= (stat_q & ~clr_bits) | rise;
                end
            end

            assign status = stat_q;

            AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> ((status & $past(src_i & ~prev_q)) == $past(src_i & ~prev_q))); // R2
            AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                !clr_we |=> (($past(status) & ~status) == '0));                          // R2
            AST_CLEAR_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
                clr_we |=> (($past(status) & ~status & ~$past(wdata)) == '0));          // R3
        end else begin : g_level
            // Level variant: status follows the inputs directly.
            assign status = src_i;
        end
    endgenerate

endmodule

// File: rtl/l2_irq_agg.sv
// Module: top of the second-level interrupt aggregator. It ties together the
// decode, the status capture and the mask, registers the read data, and
// registers the request to the parent controller.
// Assumes one register access per cycle and sources synchronous to clk.
module l2_irq_agg
    import l2_irq_pkg::*;
#(
    parameter int NSRC    = 32,
    parameter int ADDR_W  = 8,
    parameter bit LATCHED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [NSRC-1:0]   req_wdata,
    output logic [NSRC-1:0]   rd_data,
    output logic              irq_o
);
    regsel_t         sel;
    logic            clr_we;
    logic            mset_we;
    logic            mclr_we;
    logic [NSRC-1:0] status;
    logic [NSRC-1:0] mask;
    logic            rd_en;

    l2_reg_decode #(.ADDR_W(ADDR_W), .LATCHED(LATCHED)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .sel       (sel),
        .clr_we    (clr_we),
        .mset_we   (mset_we),
        .mclr_we   (mclr_we)
    );

    l2_src_capture #(.NSRC(NSRC), .LATCHED(LATCHED)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_i),
        .clr_we (clr_we),
        .wdata  (req_wdata),
        .status (status)
    );

    l2_mask_bank #(.NSRC(NSRC)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .mset_we (mset_we),
        .mclr_we (mclr_we),
        .wdata   (req_wdata),
        .mask    (mask)
    );

    assign rd_en = req_valid && !req_write;

    // Registered read mux: status and mask status are readable; all else reads zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            case (sel)
                SEL_STAT:  rd_data <= status;
                SEL_MSTAT: rd_data <= mask;
                default:   rd_data <= '0;
            endcase
        end
    end

    // Registered parent request: any pending source that is not masked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= |(status & ~mask);
        end
    end

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask) |=> !irq_o);                                              // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |=> !irq_o);                                       // R9
    AST_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel != SEL_STAT && sel != SEL_MSTAT) |=> (rd_data == '0)); // R10
    AST_RD_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_MSTAT && !mset_we && !mclr_we) |=> (rd_data == $past(mask))); // R8

endmodule

// File: tb/tb_l2_irq_agg.sv
// Bench: drives a latched instance (dut) and a level instance (dut_lvl). Every
// input changes on the falling edge and every output is sampled on the falling edge.
module tb_l2_irq_agg;
    localparam int NSRC = 32;
    localparam int AW   = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src_a = '0;
    logic [NSRC-1:0] src_b = '0;
    logic            v_a = 1'b0;
    logic            v_b = 1'b0;
    logic            wr = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic [NSRC-1:0] wdata = '0;
    logic [NSRC-1:0] rd_a, rd_b;
    logic            irq_a, irq_b;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    l2_irq_agg #(.NSRC(NSRC), .ADDR_W(AW), .LATCHED(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .src_i(src_a), .req_valid(v_a), .req_write(wr),
        .req_addr(addr), .req_wdata(wdata), .rd_data(rd_a), .irq_o(irq_a));

    l2_irq_agg #(.NSRC(NSRC), .ADDR_W(AW), .LATCHED(1'b0)) dut_lvl (
        .clk(clk), .rst_n(rst_n), .src_i(src_b), .req_valid(v_b), .req_write(wr),
        .req_addr(addr), .req_wdata(wdata), .rd_data(rd_b), .irq_o(irq_b));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // Single-cycle write; on return the register has taken the value.
    task automatic bus_wr(input bit lvl, input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        if (lvl) v_b = 1'b1; else v_a = 1'b1;
        @(negedge clk);
        v_a = 1'b0; v_b = 1'b0; wr = 1'b0; wdata = '0;
    endtask

    // Single-cycle read; the registered data is valid on return.
    task automatic bus_rd(input bit lvl, input logic [7:0] a, output logic [31:0] d);
        addr = a; wr = 1'b0;
        if (lvl) v_b = 1'b1; else v_a = 1'b1;
        @(negedge clk);
        v_a = 1'b0; v_b = 1'b0;
        d = lvl ? rd_b : rd_a;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        logic [31:0] pat;
        logic [31:0] exp_mask_b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 irq latched", {31'd0, irq_a}, 32'd0);
        chk("R1 irq level", {31'd0, irq_b}, 32'd0);
        chk("R1 rd_data", rd_a, 32'd0);
        bus_rd(0, 8'h00, d); chk("R1 status", d, 32'd0);
        bus_rd(0, 8'h0C, d); chk("R1 mask latched", d, 32'hFFFF_FFFF);
        bus_rd(1, 8'h04, d); chk("R1 mask level", d, 32'hFFFF_FFFF);

        // Latched sweep over every source: R2, R3, R7, R8, R9
        for (int i = 0; i < NSRC; i++) begin
            src_a[i] = 1'b1;
            @(negedge clk);
            src_a[i] = 1'b0;
            @(negedge clk);
            bus_rd(0, 8'h00, d); chk("R2 sticky edge", d, 32'd1 << i);
            chk("R9 masked no irq", {31'd0, irq_a}, 32'd0);
            bus_wr(0, 8'h14, 32'd1 << i);
            bus_rd(0, 8'h0C, d); chk("R7/R8 unmask one", d, ~(32'd1 << i));
            chk("R9 irq up", {31'd0, irq_a}, 32'd1);
            bus_wr(0, 8'h08, 32'd1 << i);
            bus_rd(0, 8'h00, d); chk("R3 clear", d, 32'd0);
            chk("R9 irq down", {31'd0, irq_a}, 32'd0);
            bus_wr(0, 8'h10, 32'd1 << i);
            bus_rd(0, 8'h0C, d); chk("R6 remask", d, 32'hFFFF_FFFF);
        end

        // R3: zero bits of the clear write leave status alone
        src_a[3:0] = 4'hF; @(negedge clk); src_a[3:0] = 4'h0; @(negedge clk);
        bus_wr(0, 8'h08, 32'h0000_0002);
        bus_rd(0, 8'h00, d); chk("R3 partial clear", d, 32'h0000_000D);

        // R4: edge and clear of bit 5 in the same cycle
        src_a[5] = 1'b1;
        bus_wr(0, 8'h08, 32'h0000_0020);
        src_a[5] = 1'b0;
        bus_rd(0, 8'h00, d); chk("R4 edge wins", d, 32'h0000_002D);
        bus_wr(0, 8'h08, 32'hFFFF_FFFF);
        bus_rd(0, 8'h00, d); chk("R3 clear all", d, 32'd0);

        // R6/R7: zero bits leave mask alone
        bus_wr(0, 8'h14, 32'h00FF_00FF);
        bus_wr(0, 8'h10, 32'h0000_0003);
        bus_rd(0, 8'h0C, d); chk("R6 partial set", d, 32'hFF00_FF03);
        bus_wr(0, 8'h14, 32'h0100_0000);
        bus_rd(0, 8'h0C, d); chk("R7 partial clear", d, 32'hFE00_FF03);

        // R10: unmapped and write-only offsets read zero; writes there change nothing
        bus_rd(0, 8'h04, d); chk("R10 unmapped 04", d, 32'd0);
        bus_rd(0, 8'h18, d); chk("R10 unmapped 18", d, 32'd0);
        bus_rd(0, 8'h08, d); chk("R10 wo clear", d, 32'd0);
        bus_rd(0, 8'h10, d); chk("R10 wo set", d, 32'd0);
        bus_rd(0, 8'h14, d); chk("R10 wo mclr", d, 32'd0);
        bus_wr(0, 8'h04, 32'hFFFF_FFFF);
        bus_wr(0, 8'h0C, 32'hFFFF_FFFF);
        bus_wr(0, 8'h00, 32'hFFFF_FFFF);
        bus_rd(0, 8'h0C, d); chk("R10 mask untouched", d, 32'hFE00_FF03);
        bus_rd(0, 8'h00, d); chk("R10 status untouched", d, 32'd0);
        bus_wr(0, 8'h10, 32'hFFFF_FFFF);
        bus_rd(0, 8'h0C, d); chk("R6 set all", d, 32'hFFFF_FFFF);

        // Level variant sweep: R5, R6, R7, R8, R9
        exp_mask_b = 32'hFFFF_FFFF;
        for (int i = 0; i < NSRC; i++) begin
            pat = (32'h9E37_79B9 * (i + 1)) ^ (32'd1 << i);
            src_b = pat;
            @(negedge clk);
            chk("R9 level masked", {31'd0, irq_b}, {31'd0, |(pat & ~exp_mask_b)});
            bus_rd(1, 8'h00, d); chk("R5 level status", d, pat);
            bus_wr(1, 8'h0C, 32'd1 << i);
            exp_mask_b = exp_mask_b & ~(32'd1 << i);
            bus_rd(1, 8'h04, d); chk("R8 level mask", d, exp_mask_b);
            chk("R9 level irq", {31'd0, irq_b}, {31'd0, |(pat & ~exp_mask_b)});
            src_b = '0;
            @(negedge clk);
            chk("R9 level drop", {31'd0, irq_b}, 32'd0);
        end
        bus_wr(1, 8'h08, 32'h0F0F_0F0F);
        bus_rd(1, 8'h04, d); chk("R6 level set", d, 32'h0F0F_0F0F);
        src_b = 32'h0000_0010; @(negedge clk);
        chk("R9 level unmasked bit", {31'd0, irq_b}, 32'd1);
        src_b = 32'h0000_0001; @(negedge clk);
        chk("R9 level masked bit", {31'd0, irq_b}, 32'd0);
        src_b = '0;
        bus_rd(1, 8'h10, d); chk("R10 level unmapped 10", d, 32'd0);
        bus_rd(1, 8'h08, d); chk("R10 level wo set", d, 32'd0);
        bus_rd(1, 8'h0C, d); chk("R10 level wo clr", d, 32'd0);
        bus_wr(1, 8'h14, 32'hFFFF_FFFF);
        bus_rd(1, 8'h04, d); chk("R10 level 14 ignored", d, 32'h0F0F_0F0F);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule